// File: doc/BRIEF.md
# SDRAM command decoder and bank tracker

This block sits on the command side of an SDRAM controller or memory model. On every rising clock edge it samples the chip select, the row strobe, the column strobe, the write enable, the address bus, the bank-select pins and the clock enable. From these it decodes one command. It keeps a per-bank record of whether a row is open and which row that is. It reports the accepted command with its bank, row and column fields, the auto-precharge and precharge-all flags, and the current low-power state of the device.

The four banks are independent. An activate opens one bank. A read or write may close its own bank through the auto-precharge bit. A precharge closes one bank or all of them. Commands that the bank state does not allow are flagged for one cycle, and they leave the bank state as it was. The clock-enable pin moves the device into power-down or self-refresh and back out again. A clock-enable level that lasts only one sample is reported as a violation. Timing intervals, data strobes and the data path lie outside this block.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: The command is taken from the three strobes {ras_n, cas_n, we_n}, all active low: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, 110 burst stop, 111 no-operation. `cmd_o` carries that 3-bit code in the cycle after the sampling edge. When no command is accepted, `cmd_o` is 111 and `bank_o`, `row_o`, `col_o`, `auto_pre_o` and `pre_all_o` are 0.
- R2: The bank index is 2*BA0 + BA1, where `ba[1]` is BA1 and `ba[0]` is BA0, so BA0 is the high-order bank bit. `bank_o` reports that index.
- R3: An activate to an idle bank opens it and records all 13 address bits as its row. `row_o` shows the address. An activate to a bank that is already open raises `illegal_o` for one cycle and changes no bank state.
- R4: On a read or write, `col_o` is address bits 8..0. A read or write to an idle bank raises `illegal_o` and changes no bank state.
- R5: A legal read or write with address bit 10 high sets `auto_pre_o` and leaves its bank idle afterwards. With bit 10 low the row stays open.
- R6: A precharge with address bit 10 high closes every bank and sets `pre_all_o`. With bit 10 low it closes only the addressed bank. A precharge to an idle bank is legal.
- R7: Refresh and mode register set are legal only when all banks are idle. Otherwise they raise `illegal_o`.
- R8: While `cs_n` is high no command is accepted, and the open state and row of every bank are kept.
- R9: `pwr_mode_o` is 0 for active, 1 for power-down and 2 for self-refresh. `cke` sampled low in the active state enters self-refresh if the command at that edge is a refresh and all banks are idle. Otherwise it enters power-down, and a refresh at that edge with an open bank also raises `illegal_o`. No command is accepted while in power-down or self-refresh, nor at the edge where `cke` is sampled high again, which returns the state to active.
- R10: `cke_viol_o` is high for one cycle after an edge at which `cke` differs from the previous sample while that previous sample differed from the one before it.
- R11: After reset all banks are idle with row 0, the power state is active, and every output flag is 0 with `cmd_o` at 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Address bus; bit 10 is the precharge/auto-precharge bit |
| ba | input | 2 | Bank select: ba[1] is BA1, ba[0] is BA0 |
| cke | input | 1 | Clock enable |
| cmd_o | output | 3 | Accepted command code |
| bank_o | output | 2 | Bank index of the accepted command |
| row_o | output | 13 | Address captured with the command |
| col_o | output | 9 | Column field of the command |
| auto_pre_o | output | 1 | Legal read/write with auto-precharge |
| pre_all_o | output | 1 | Precharge of all banks |
| illegal_o | output | 1 | Command not allowed in the current bank state |
| pwr_mode_o | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| cke_viol_o | output | 1 | Clock-enable level held for only one sample |
| bank_open_o | output | 4 | Bit i set when bank i has an open row |
| open_rows_o | output | 52 | Open row of bank i at bits [13*i+12 : 13*i], 0 if idle |

## Verification
The case that needs the most care is a clock-enable fall that lands on the same edge as a refresh command. At that edge the block must decide between self-refresh entry and plain power-down, and it must also judge the refresh against the bank state. The bench provokes this both with all banks idle and with one bank still open. A reference model in the bench predicts the power state, the illegal flag and the unchanged bank table for each case. The second case of this kind is a read or write with auto-precharge issued right after other commands to the same bank, where the open bit must clear in the same cycle that the flag is reported.

// File: rtl/sdcmd_pkg.sv
// Shared command and power-state encodings for the SDRAM command tracker.
// Assumes the strobe triple {ras_n, cas_n, we_n} is used directly as the code.
package sdcmd_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_DOWN   = 2'd1,
        PWR_SELF   = 2'd2
    } pwr_e;

endpackage

// File: rtl/sdcmd_decode.sv
// Combinational command decode.
// Turns the strobes into a command code (no-operation when deselected) and
// maps the bank pins to a bank index with the pin order reversed, so the
// lowest bank pin becomes the most significant index bit.
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    output cmd_e            raw_cmd,
    output logic [BA_W-1:0] bank_idx
);

    // Command code from the strobe triple; deselect reads as no-operation.
    always_comb begin
        if (cs_n) raw_cmd = CMD_NOP;
        else      raw_cmd = cmd_e'({ras_n, cas_n, we_n});
    end

    // Reverse the bank pin order into the bank index.
    for (genvar i = 0; i < BA_W; i++) begin : g_bank_rev
        assign bank_idx[i] = ba[BA_W-1-i];
    end

endmodule

// File: rtl/sdcmd_power.sv
// Low-power state tracker and clock-enable pulse-width monitor.
// Assumes cke is sampled on the same edge as the command strobes. A refresh
// seen together with a falling cke is a self-refresh attempt; any other
// falling cke enters power-down. A high cke sample always returns to active.
module sdcmd_power
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  cmd_e raw_cmd,
    input  logic all_idle,
    output pwr_e mode,
    output logic accept,
    output logic sr_try,
    output logic cke_viol
);

    logic cke_d1;
    logic cke_d2;

    // Commands are taken only while active with cke held high.
    assign accept = (mode == PWR_ACTIVE) && cke;
    // Refresh at the edge where cke is first seen low.
    assign sr_try = (mode == PWR_ACTIVE) && !cke && (raw_cmd == CMD_REF);

    // Power-state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= PWR_ACTIVE;
        end else begin
            case (mode)
                PWR_ACTIVE: if (!cke) mode <= (sr_try && all_idle) ? PWR_SELF : PWR_DOWN;
                default:    if (cke)  mode <= PWR_ACTIVE;
            endcase
        end
    end

    // Two-deep cke history and flag for a level that lasted a single sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_d1   <= 1'b1;
            cke_d2   <= 1'b1;
            cke_viol <= 1'b0;
        end else begin
            cke_d1   <= cke;
            cke_d2   <= cke_d1;
            cke_viol <= (cke_d1 != cke_d2) && (cke != cke_d1);
        end
    end

    // R9
    sr_entry_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PWR_SELF && $past(mode) == PWR_ACTIVE) |-> $past(all_idle));

    // R9
    low_power_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) != PWR_ACTIVE && !$past(cke)) |-> (mode == $past(mode)));

endmodule

// File: rtl/sdcmd_bank.sv
// One bank's open-row record.
// Assumes the caller has already judged legality: open_req arrives only for an
// idle bank. A close clears the row so that an idle bank reports row 0.
module sdcmd_bank #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);

    // Open-state and row register for this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row_q   <= '0;
        end else if (open_req) begin
            is_open <= 1'b1;
            row_q   <= row_in;
        end else if (close_req) begin
            is_open <= 1'b0;
            row_q   <= '0;
        end
    end

    // R3
    no_double_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_req |-> !is_open);

    // R6
    no_open_close_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_req && close_req));

endmodule

// File: rtl/sdram_cmd_tracker.sv
// SDRAM command decoder and per-bank open-row tracker (top level).
// Samples the command pins every rising edge. It judges each accepted command
// against the bank table, updates that table, and registers the decoded fields
// for one cycle. Assumes the precharge/auto-precharge flag sits at address bit
// AP_BIT and that the column field is the low COL_W address bits.
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10,
    localparam int NBANK = 1 << BA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [ROW_W-1:0]       addr,
    input  logic [BA_W-1:0]        ba,
    input  logic                   cke,
    output logic [2:0]             cmd_o,
    output logic [BA_W-1:0]        bank_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [COL_W-1:0]       col_o,
    output logic                   auto_pre_o,
    output logic                   pre_all_o,
    output logic                   illegal_o,
    output logic [1:0]             pwr_mode_o,
    output logic                   cke_viol_o,
    output logic [NBANK-1:0]       bank_open_o,
    output logic [NBANK*ROW_W-1:0] open_rows_o
);

    cmd_e            raw_cmd;
    cmd_e            eff_cmd;
    logic [BA_W-1:0] sel_bank;
    pwr_e            mode_w;
    logic            accept;
    logic            sr_try;
    logic            all_idle;
    logic            sel_open;
    logic            bad;
    logic            is_rw;
    logic            ap_bit;
    logic [NBANK-1:0] open_req;
    logic [NBANK-1:0] close_req;

    sdcmd_decode #(.BA_W(BA_W)) u_decode (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ba      (ba),
        .raw_cmd (raw_cmd),
        .bank_idx(sel_bank)
    );

    sdcmd_power u_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .raw_cmd (raw_cmd),
        .all_idle(all_idle),
        .mode    (mode_w),
        .accept  (accept),
        .sr_try  (sr_try),
        .cke_viol(cke_viol_o)
    );

    assign pwr_mode_o = mode_w;
    assign all_idle   = (bank_open_o == '0);
    assign sel_open   = bank_open_o[sel_bank];
    assign ap_bit     = addr[AP_BIT];

    // Command that takes effect this edge, after power and select gating.
    always_comb begin
        if (accept)      eff_cmd = raw_cmd;
        else if (sr_try) eff_cmd = CMD_REF;
        else             eff_cmd = CMD_NOP;
    end

    assign is_rw = (eff_cmd == CMD_RD) || (eff_cmd == CMD_WR);

    // Legality of the effective command against the bank table.
    always_comb begin
        case (eff_cmd)
            CMD_ACT:         bad = sel_open;
            CMD_RD, CMD_WR:  bad = !sel_open;
            CMD_REF, CMD_MRS: bad = !all_idle;
            default:         bad = 1'b0;
        endcase
    end

    // One record per bank, each with its own open and close strobes.
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic hit;
        assign hit = (sel_bank == BA_W'(i));
        assign open_req[i]  = !bad && (eff_cmd == CMD_ACT) && hit;
        assign close_req[i] = !bad && (((eff_cmd == CMD_PRE) && (ap_bit || hit)) ||
                                       (is_rw && ap_bit && hit));
        sdcmd_bank #(.ROW_W(ROW_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_req (open_req[i]),
            .close_req(close_req[i]),
            .row_in   (addr),
            .is_open  (bank_open_o[i]),
            .row_q    (open_rows_o[i*ROW_W +: ROW_W])
        );
    end

    // Registered report of the command accepted at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n || eff_cmd == CMD_NOP) begin
            cmd_o      <= CMD_NOP;
            bank_o     <= '0;
            row_o      <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            pre_all_o  <= 1'b0;
            illegal_o  <= 1'b0;
        end else begin
            cmd_o      <= eff_cmd;
            bank_o     <= sel_bank;
            row_o      <= addr;
            col_o      <= addr[COL_W-1:0];
            auto_pre_o <= is_rw && ap_bit && !bad;
            pre_all_o  <= (eff_cmd == CMD_PRE) && ap_bit;
            illegal_o  <= bad;
        end
    end

    // R3 R4 R7
    illegal_freezes_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (bank_open_o == $past(bank_open_o)) && (open_rows_o == $past(open_rows_o)));

    // R6
    pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |-> (bank_open_o == '0));

    // R5
    auto_pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> !bank_open_o[bank_o]);

    // R3
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && !illegal_o) |->
            (bank_open_o[bank_o] && open_rows_o[bank_o*ROW_W +: ROW_W] == row_o));

    // R8
    deselect_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> ($stable(bank_open_o) && $stable(open_rows_o)));

    // R1
    illegal_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cmd_o != CMD_NOP));

endmodule

// File: tb/sdram_cmd_tracker_bench.sv
// Self-checking bench: a behavioural model of the requirements predicts every
// output after each edge; sweeps cover all codes, banks and power transitions.
module sdram_cmd_tracker_bench;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic        cke = 1'b1;
    logic [2:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] row_o;
    logic [8:0]  col_o;
    logic        auto_pre_o, pre_all_o, illegal_o, cke_viol_o;
    logic [1:0]  pwr_mode_o;
    logic [3:0]  bank_open_o;
    logic [51:0] open_rows_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic [3:0]  m_open = '0;
    logic [12:0] m_row [4] = '{default: '0};
    int          m_mode = 0;
    logic        m_c1 = 1'b1, m_c2 = 1'b1;

    always #(CLK_NS/2) clk = ~clk;

    sdram_cmd_tracker u_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .ba(ba), .cke(cke), .cmd_o(cmd_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
        .pre_all_o(pre_all_o), .illegal_o(illegal_o), .pwr_mode_o(pwr_mode_o),
        .cke_viol_o(cke_viol_o), .bank_open_o(bank_open_o), .open_rows_o(open_rows_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [51:0] pack_rows();
        logic [51:0] v;
        for (int i = 0; i < 4; i++) v[i*13 +: 13] = m_row[i];
        return v;
    endfunction

    // Drive one sample, advance the model, then compare every output.
    task automatic step(input logic cs, input logic [2:0] c, input logic [1:0] b,
                        input logic [12:0] a, input logic ke, input string tag);
        int          bi;
        logic [2:0]  e_cmd;
        logic        e_ill, e_ap, e_pall, e_viol, acc, all_idle;
        bi = b[0] * 2 + b[1];
        all_idle = (m_open == 4'b0);
        acc = 1'b0; e_ill = 1'b0; e_ap = 1'b0; e_pall = 1'b0; e_cmd = 3'b111;
        e_viol = (m_c1 != m_c2) && (ke != m_c1);
        m_c2 = m_c1; m_c1 = ke;
        if (m_mode == 0) begin
            if (ke) begin
                acc = !cs && (c != 3'b111);
            end else begin
                acc = !cs && (c == 3'b001);
                m_mode = (acc && all_idle) ? 2 : 1;
            end
        end else if (ke) begin
            m_mode = 0;
        end
        if (acc) begin
            e_cmd = c;
            case (c)
                3'b011: e_ill = m_open[bi];
                3'b101, 3'b100: e_ill = !m_open[bi];
                3'b001, 3'b000: e_ill = !all_idle;
                default: e_ill = 1'b0;
            endcase
            if (!e_ill) begin
                if (c == 3'b011) begin
                    m_open[bi] = 1'b1; m_row[bi] = a;
                end
                if ((c == 3'b101 || c == 3'b100) && a[10]) begin
                    e_ap = 1'b1; m_open[bi] = 1'b0; m_row[bi] = '0;
                end
                if (c == 3'b010) begin
                    e_pall = a[10];
                    for (int i = 0; i < 4; i++)
                        if (a[10] || i == bi) begin m_open[i] = 1'b0; m_row[i] = '0; end
                end
            end
        end
        @(negedge clk);
        cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a; cke = ke;
        @(posedge clk);
        #2;
        check(cmd_o == e_cmd, "R1 cmd", 64'(cmd_o), 64'(e_cmd));
        check(bank_o == (acc ? 2'(bi) : 2'd0), "R2 bank", 64'(bank_o), 64'(acc ? bi : 0));
        check(row_o == (acc ? a : 13'd0), "R3 row", 64'(row_o), 64'(acc ? a : 13'd0));
        check(col_o == (acc ? a[8:0] : 9'd0), "R4 col", 64'(col_o), 64'(acc ? a[8:0] : 9'd0));
        check(auto_pre_o == e_ap, "R5 auto-precharge", 64'(auto_pre_o), 64'(e_ap));
        check(pre_all_o == e_pall, "R6 precharge-all", 64'(pre_all_o), 64'(e_pall));
        check(illegal_o == e_ill, {tag, " illegal"}, 64'(illegal_o), 64'(e_ill));
        check(bank_open_o == m_open, {tag, " bank open"}, 64'(bank_open_o), 64'(m_open));
        check(open_rows_o == pack_rows(), {tag, " open rows"}, 64'(open_rows_o), 64'(pack_rows()));
        check(pwr_mode_o == 2'(m_mode), "R9 power mode", 64'(pwr_mode_o), 64'(m_mode));
        check(cke_viol_o == e_viol, "R10 cke violation", 64'(cke_viol_o), 64'(e_viol));
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        check(cmd_o == 3'b111 && bank_o == 0 && row_o == 0 && col_o == 0, "R11 fields",
              64'({cmd_o, bank_o, row_o, col_o}), 64'({3'b111, 24'd0}));
        check({auto_pre_o, pre_all_o, illegal_o, cke_viol_o} == 4'b0, "R11 flags",
              64'({auto_pre_o, pre_all_o, illegal_o, cke_viol_o}), 64'd0);
        check(bank_open_o == 0 && open_rows_o == 0 && pwr_mode_o == 0, "R11 banks",
              64'(bank_open_o), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3: open each bank by pin value, then re-activate (illegal)
        for (int b = 0; b < 4; b++) step(0, 3'b011, 2'(b), 13'h1000 | 13'(b * 13'h111), 1, "R3");
        for (int b = 0; b < 4; b++) step(0, 3'b011, 2'(b), 13'h0abc, 1, "R3");

        // R8: every code deselected leaves everything alone
        for (int c = 0; c < 8; c++) step(1, 3'(c), 2'(c), 13'h1fff, 1, "R8");

        // R4: reads and writes to open banks, column field, A10 low
        for (int b = 0; b < 4; b++) begin
            step(0, 3'b101, 2'(b), 13'h01a5 + 13'(b), 1, "R4");
            step(0, 3'b100, 2'(b), 13'h1b5a - 13'(b), 1, "R4");
        end

        // R7: refresh and mode set with banks open
        step(0, 3'b001, 2'd0, 13'h0000, 1, "R7");
        step(0, 3'b000, 2'd1, 13'h0033, 1, "R7");

        // R5: auto-precharge closes one bank; then an idle-bank read is illegal (R4)
        step(0, 3'b101, 2'b00, 13'h0400 | 13'h012, 1, "R5");
        step(0, 3'b100, 2'b01, 13'h0400 | 13'h0ff, 1, "R5");
        step(0, 3'b101, 2'b00, 13'h0001, 1, "R4");
        step(0, 3'b100, 2'b01, 13'h0001, 1, "R4");

        // R6: single precharge, precharge of an idle bank, precharge all
        step(0, 3'b010, 2'b10, 13'h0000, 1, "R6");
        step(0, 3'b010, 2'b10, 13'h0000, 1, "R6");
        step(0, 3'b010, 2'b00, 13'h0400, 1, "R6");

        // R7: legal when idle
        step(0, 3'b001, 2'd0, 13'h0000, 1, "R7");
        step(0, 3'b000, 2'd0, 13'h0021, 1, "R7");

        // Sweep: every code on every bank pin value with several addresses
        for (int p = 0; p < 3; p++)
            for (int c = 0; c < 8; c++)
                for (int b = 0; b < 4; b++)
                    step(0, 3'(c), 2'(b), 13'((p * 13'h0a31 + c * 13'h0107 + b * 13'h0529) ^ (p == 1 ? 13'h0400 : 13'h0)), 1, "R3");

        // R9: power-down with a bank open, ignored commands, exit edge ignored
        step(0, 3'b010, 2'd0, 13'h0400, 1, "R6");
        step(0, 3'b011, 2'b11, 13'h0777, 1, "R3");
        step(0, 3'b111, 2'd0, 13'h0000, 1, "R9");
        step(0, 3'b111, 2'd0, 13'h0000, 0, "R9");
        step(0, 3'b011, 2'd0, 13'h0123, 0, "R9");
        step(0, 3'b010, 2'd0, 13'h0400, 0, "R9");
        step(0, 3'b011, 2'd0, 13'h0123, 1, "R9");
        step(0, 3'b011, 2'd1, 13'h0321, 1, "R9");

        // R9 R7: refresh at cke fall with a bank open -> illegal, power-down
        step(0, 3'b001, 2'd0, 13'h0000, 0, "R7");
        step(0, 3'b111, 2'd0, 13'h0000, 0, "R9");
        step(0, 3'b111, 2'd0, 13'h0000, 1, "R9");

        // R9: self-refresh entry with all banks idle, hold, exit
        step(0, 3'b010, 2'd0, 13'h0400, 1, "R6");
        step(0, 3'b001, 2'd0, 13'h0000, 0, "R9");
        step(0, 3'b001, 2'd0, 13'h0000, 0, "R9");
        step(1, 3'b111, 2'd0, 13'h0000, 0, "R9");
        step(0, 3'b011, 2'd2, 13'h0555, 1, "R9");
        step(0, 3'b011, 2'd2, 13'h0555, 1, "R3");

        // R10: one-sample cke pulses, both polarities
        step(1, 3'b111, 2'd0, 13'h0000, 1, "R10");
        step(1, 3'b111, 2'd0, 13'h0000, 0, "R10");
        step(1, 3'b111, 2'd0, 13'h0000, 1, "R10");
        step(1, 3'b111, 2'd0, 13'h0000, 0, "R10");
        step(1, 3'b111, 2'd0, 13'h0000, 0, "R10");
        step(1, 3'b111, 2'd0, 13'h0000, 1, "R10");
        step(1, 3'b111, 2'd0, 13'h0000, 1, "R10");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule